// File: doc/BRIEF.md
# Vector Memory-Op Effective Width Decoder

This block sits in the decode stage of a vector unit. For each vector load or store, it resolves the element width and register-group multiplier that the instruction will actually use. The inputs are a 2-bit width code from the instruction, a flag that marks indexed accesses, the data and index register numbers, and the current element width (SEW) and group multiplier (LMUL) held in the vector type state. The block only reads that state and never writes it back. The resolved width and multiplier apply to this one instruction only.

For unit-stride and strided accesses, the width code replaces SEW for both the register element and the memory element. The multiplier is then rescaled so that the ratio of width to multiplier stays the same. For indexed accesses, the data side keeps SEW and LMUL unchanged, and the width code sizes only the index vector. In that case the top code selects 64 bits rather than SEW.

An instruction is flagged illegal in three cases: a rescaled multiplier falls outside 1/8..8, a register group is misaligned for its multiplier, or the LMUL input carries its reserved code. All results are registered and appear one cycle after the input strobe.

Top module: `vmem_eew_decode`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. Reset clears `out_valid` and `illegal`.
- R2: Width and SEW codes both use 00=8, 01=16, 10=32, 11=64 bits. For a non-indexed access, the width code maps 00→8, 01→16, 10→32, and 11→current SEW. That value is reported on `data_eew`. For non-indexed accesses, `idx_eew` and `idx_emul` read 0, and `idx_reg` has no effect on any output.
- R3: Multipliers are two's-complement log2 values (-3 = 1/8 … 3 = 8). For a non-indexed access, `data_emul` = log2(EEW) − log2(SEW) + `lmul_log2`. Hence log2(EEW) − `data_emul` equals log2(SEW) − `lmul_log2`.
- R4: `illegal` is set when a computed multiplier (data, or index when indexed) lies outside -3..3.
- R5: For an indexed access, `data_eew` = SEW and `data_emul` = `lmul_log2`. The width code gives `idx_eew` with 11 meaning 64 bits. `idx_emul` = log2(index EEW) − log2(SEW) + `lmul_log2`.
- R6: When a group's multiplier log2 is k > 0, the register number of that group must have its low k bits zero, or `illegal` is set. This applies to `data_reg` for the data group and to `idx_reg` for the index group when indexed. Fractional and unit multipliers impose no alignment.
- R7: An `lmul_log2` value of -4 (3'b100) is reserved and sets `illegal`.
- R8: While `in_valid` is low, the width, multiplier and `illegal` outputs hold their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| width_code | input | 2 | Width field of the instruction |
| is_indexed | input | 1 | Access uses an index vector |
| data_reg | input | REG_W | Data register group base number |
| idx_reg | input | REG_W | Index register group base number |
| sew_code | input | 2 | Current SEW, 00=8 … 11=64 |
| lmul_log2 | input | 3 | Current LMUL as signed log2 |
| out_valid | output | 1 | Results below belong to the previous cycle's instruction |
| data_eew | output | 2 | Data element width code |
| data_emul | output | 3 | Data group multiplier, signed log2 |
| idx_eew | output | 2 | Index element width code |
| idx_emul | output | 3 | Index group multiplier, signed log2 |
| illegal | output | 1 | Instruction raises an illegal-instruction exception |

## Verification
On every cycle, the assertions check several properties. The valid strobe must be delayed by exactly one cycle. A legal result must preserve the width-to-multiplier ratio. An indexed access must keep SEW and LMUL for its data group. A legal result must carry a multiplier inside -3..3 and an aligned data group. Outputs must hold while no instruction arrives. Only the bench's scenarios can show the exact code-to-width mapping, the flagging of particular out-of-range and misaligned cases, the reserved LMUL code, and the fact that the index register is ignored for non-indexed accesses.

// File: rtl/vmem_eew_decode.sv
module vmem_eew_decode #(
  parameter int REG_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [1:0]             width_code,
  input  logic                   is_indexed,
  input  logic [REG_W-1:0]       data_reg,
  input  logic [REG_W-1:0]       idx_reg,
  input  logic [1:0]             sew_code,
  input  logic signed [2:0]      lmul_log2,
  output logic                   out_valid,
  output logic [1:0]             data_eew,
  output logic signed [2:0]      data_emul,
  output logic [1:0]             idx_eew,
  output logic signed [2:0]      idx_emul,
  output logic                   illegal
);

  function automatic logic in_range(input logic signed [4:0] e);
    return (e >= -5'sd3) && (e <= 5'sd3);
  endfunction

  function automatic logic aligned(input logic [REG_W-1:0] r, input logic signed [4:0] e);
    case (e)
      5'sd1:   return r[0] == 1'b0;
      5'sd2:   return r[1:0] == 2'b00;
      5'sd3:   return r[2:0] == 3'b000;
      default: return 1'b1;
    endcase
  endfunction

  logic [1:0]        d_eew_c, i_eew_c;
  logic signed [4:0] lmul_x, d_emul_x, i_emul_x;
  logic              lmul_rsvd, d_bad, i_bad, bad;

  assign d_eew_c   = (is_indexed || width_code == 2'b11) ? sew_code : width_code;
  assign i_eew_c   = is_indexed ? width_code : 2'b00;
  assign lmul_x    = {{2{lmul_log2[2]}}, lmul_log2};
  assign d_emul_x  = $signed({3'b000, d_eew_c}) - $signed({3'b000, sew_code}) + lmul_x;
  assign i_emul_x  = is_indexed ? ($signed({3'b000, i_eew_c}) - $signed({3'b000, sew_code}) + lmul_x) : 5'sd0;
  assign lmul_rsvd = (lmul_log2 == -3'sd4);
  assign d_bad     = !in_range(d_emul_x) || !aligned(data_reg, d_emul_x);
  assign i_bad     = is_indexed && (!in_range(i_emul_x) || !aligned(idx_reg, i_emul_x));
  assign bad       = lmul_rsvd || d_bad || i_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      data_eew  <= 2'b00;
      data_emul <= 3'sd0;
      idx_eew   <= 2'b00;
      idx_emul  <= 3'sd0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        data_eew  <= d_eew_c;
        data_emul <= d_emul_x[2:0];
        idx_eew   <= i_eew_c;
        idx_emul  <= i_emul_x[2:0];
        illegal   <= bad;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  ratio_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bad && !is_indexed) |=>
      (int'(data_eew) - int'(data_emul) == int'($past(sew_code)) - int'($past(lmul_log2))));
  // R4
  emul_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !illegal) |-> (data_emul != -3'sd4));
  // R5
  idx_data_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_indexed) |=> (data_eew == $past(sew_code) && data_emul == $past(lmul_log2)));
  // R6
  data_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bad && d_emul_x > 5'sd0) |-> (data_reg[0] == 1'b0));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(data_eew) && $stable(data_emul) && $stable(idx_eew) &&
                   $stable(idx_emul) && $stable(illegal)));

endmodule

// File: tb/tb_vmem_eew_decode.sv
module tb_vmem_eew_decode;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] width_code = 2'b00;
  logic is_indexed = 1'b0;
  logic [4:0] data_reg = 5'd0, idx_reg = 5'd0;
  logic [1:0] sew_code = 2'b00;
  logic signed [2:0] lmul_log2 = 3'sd0;
  logic out_valid, illegal;
  logic [1:0] data_eew, idx_eew;
  logic signed [2:0] data_emul, idx_emul;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  vmem_eew_decode #(.REG_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .width_code(width_code),
    .is_indexed(is_indexed), .data_reg(data_reg), .idx_reg(idx_reg),
    .sew_code(sew_code), .lmul_log2(lmul_log2), .out_valid(out_valid),
    .data_eew(data_eew), .data_emul(data_emul), .idx_eew(idx_eew),
    .idx_emul(idx_emul), .illegal(illegal));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic ix, input logic [1:0] wc, input logic [1:0] sc,
                       input logic signed [2:0] lm, input logic [4:0] dr, input logic [4:0] ir);
    @(negedge clk);
    is_indexed = ix; width_code = wc; sew_code = sc; lmul_log2 = lm;
    data_reg = dr; idx_reg = ir; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_all(input string req, input int de, input int dm,
                            input int ie, input int im, input int ill);
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " data_eew"}, int'(data_eew), de);
    check({req, " data_emul"}, int'(data_emul), dm);
    check({req, " idx_eew"}, int'(idx_eew), ie);
    check({req, " idx_emul"}, int'(idx_emul), im);
    check({req, " illegal"}, int'(illegal), ill);
  endtask

  task automatic t_reset;
    check("R1 reset out_valid", int'(out_valid), 0);
    check("R1 reset illegal", int'(illegal), 0);
  endtask

  task automatic t_widen_nonidx;
    issue(1'b0, 2'b10, 2'b01, 3'sd2, 5'd16, 5'd0);
    expect_all("R2 R3 sew16 m4 w32", 2, 3, 0, 0, 0);
    issue(1'b0, 2'b11, 2'b01, 3'sd2, 5'd4, 5'd0);
    expect_all("R2 code11 is SEW", 1, 2, 0, 0, 0);
    issue(1'b0, 2'b00, 2'b10, 3'sd3, 5'd2, 5'd0);
    expect_all("R3 sew32 m8 w8", 0, 1, 0, 0, 0);
  endtask

  task automatic t_range;
    issue(1'b0, 2'b10, 2'b00, 3'sd3, 5'd0, 5'd0);
    check("R4 emul too large", int'(illegal), 1);
    issue(1'b0, 2'b00, 2'b11, -3'sd3, 5'd0, 5'd0);
    check("R4 emul too small", int'(illegal), 1);
  endtask

  task automatic t_indexed;
    issue(1'b1, 2'b00, 2'b10, 3'sd2, 5'd8, 5'd7);
    expect_all("R5 sew32 m4 idx8", 2, 2, 0, 0, 0);
    issue(1'b1, 2'b11, 2'b00, -3'sd1, 5'd1, 5'd8);
    expect_all("R5 sew8 mf2 idx64", 0, -1, 3, 2, 0);
  endtask

  task automatic t_align;
    issue(1'b1, 2'b11, 2'b00, -3'sd1, 5'd1, 5'd9);
    check("R6 index group misaligned", int'(illegal), 1);
    issue(1'b0, 2'b10, 2'b01, 3'sd2, 5'd4, 5'd0);
    check("R6 data group misaligned", int'(illegal), 1);
    issue(1'b0, 2'b00, 2'b01, -3'sd1, 5'd3, 5'd0);
    check("R6 fractional no alignment", int'(illegal), 0);
  endtask

  task automatic t_idx_ignored;
    issue(1'b0, 2'b10, 2'b01, 3'sd2, 5'd8, 5'd3);
    expect_all("R2 idx_reg ignored", 2, 3, 0, 0, 0);
  endtask

  task automatic t_rsvd_lmul;
    issue(1'b0, 2'b11, 2'b01, -3'sd4, 5'd0, 5'd0);
    check("R7 reserved lmul", int'(illegal), 1);
  endtask

  task automatic t_hold;
    issue(1'b1, 2'b00, 2'b10, 3'sd2, 5'd8, 5'd7);
    @(negedge clk);
    width_code = 2'b11; sew_code = 2'b00; lmul_log2 = 3'sd3; is_indexed = 1'b0;
    data_reg = 5'd1;
    repeat (2) @(negedge clk);
    check("R8 hold out_valid low", int'(out_valid), 0);
    check("R8 hold data_eew", int'(data_eew), 2);
    check("R8 hold data_emul", int'(data_emul), 2);
    check("R8 hold illegal", int'(illegal), 0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    is_indexed = 1'b0; width_code = 2'b01; sew_code = 2'b10; lmul_log2 = 3'sd0;
    data_reg = 5'd0; idx_reg = 5'd0; in_valid = 1'b1;
    @(negedge clk);
    check("R1 first of pair valid", int'(out_valid), 1);
    check("R1 first of pair emul", int'(data_emul), -1);
    width_code = 2'b11; sew_code = 2'b11; lmul_log2 = 3'sd1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 second of pair valid", int'(out_valid), 1);
    check("R1 second of pair eew", int'(data_eew), 3);
    check("R1 second of pair emul", int'(data_emul), 1);
    @(negedge clk);
    check("R1 valid drops", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_widen_nonidx();
    t_range();
    t_indexed();
    t_align();
    t_idx_ignored();
    t_rsvd_lmul();
    t_hold();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule